// File: doc/BRIEF.md
# Mixed-Criticality Hardware Task Scheduler

This block keeps a small table of task entries and picks, every cycle, which ready task should run next. Each task is placed in one of three criticality classes: background (lowest), soft real-time and hard real-time (highest). A ready task in a higher class always beats every ready task in a lower class. Inside a class the winner is chosen by that class's own rule:

- background tasks go in the order they became ready;
- soft tasks go shortest period first;
- hard tasks go nearest absolute deadline first.

A task is only ever ready or running. There is no blocked or sleeping state. A task that has to wait is retired and later brought back by the built-in period timer.

Software talks to the block through a single valid/ready command stream. A command can configure an entry, release it or remove it. A sender holds a command and its fields steady until it sees `cmd_valid && cmd_ready` at a rising edge. `cmd_ready` is low only while reset is asserted and for the first edge after it. The chosen task leaves as a plain registered pair, `disp_valid` and `disp_id`. The processor pulses `task_done` when the running task finishes its current job.

Top module: `mcs_sched`

## Requirements
- R1: Class codes are 0 = background, 1 = soft, 2 = hard. A ready task of a higher code always wins over any ready task of a lower code.
- R2: Among ready background tasks, the one released earliest wins. Release order is recorded as a SEQ_W-bit sequence number that increments across wrap, using wrap-safe comparison. Ready tasks must lie within 2^(SEQ_W-1) releases of each other.
- R3: Among ready soft tasks, the one with the smallest period field wins.
- R4: Among ready hard tasks, the one with the nearest absolute deadline wins. The absolute deadline is the free-running cycle time at release plus the relative deadline. It is compared by the sign of the 16-bit difference, so the result is correct across timer wrap.
- R5: Equal keys within a class are resolved toward the lower task index.
- R6: A `task_done` pulse while `disp_valid` is high clears the ready flag of task `disp_id`. The dispatch output reflects this one edge later.
- R7: A configured entry with a period P > 0 is released by the timer at the edge P cycles after its configure command was accepted, and again every P cycles after that. P = 0 means the entry is released only by command.
- R8: A release, from a command or from the timer, of a task that is already ready changes nothing, including its position in first-come order. A release of an invalid entry also changes nothing.
- R9: Commands are accepted on `cmd_valid && cmd_ready`. Opcodes are 0 = configure, 1 = release, 2 = remove, 3 = no operation. Configure loads the class, period and relative deadline and leaves the task not ready. Configure with class 3 is ignored. Remove invalidates the entry and drops it from dispatch. Only valid entries can be ready.
- R10: After reset no task is valid, `disp_valid` is 0, and `cmd_ready` is 1 from the first edge after reset is released.
- R11: `disp_valid`/`disp_id` are registered. They show the selection over the table as it stood after the previous edge, so a command accepted at edge k shows at edge k+1 and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | Opcode: 0 configure, 1 release, 2 remove, 3 no-op |
| cmd_id | input | $clog2(N) | Target task index |
| cmd_cls | input | 2 | Class for configure |
| cmd_period | input | TIME_W | Period for configure (0 = command-released only) |
| cmd_rel_dl | input | TIME_W | Relative deadline for configure |
| task_done | input | 1 | Running task finished its job |
| disp_valid | output | 1 | A task is selected |
| disp_id | output | $clog2(N) | Selected task index |

## Verification
The bench builds the block with N = 8 and TIME_W = 16, but shrinks SEQ_W to 4. The short sequence number means a few dozen releases carry the first-come order across its wrap, so every alignment of three back-to-back releases straddling the wrap point is exercised. The 16-bit time base is kept, and the bench idles about 40,000 cycles so that one hard deadline wraps past zero while a competing one does not. This separates wrap-safe deadline comparison from plain unsigned comparison.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    CLS_BG   = 2'd0,
    CLS_SOFT = 2'd1,
    CLS_HARD = 2'd2,
    CLS_BAD  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    OP_CONFIG  = 2'd0,
    OP_RELEASE = 2'd1,
    OP_REMOVE  = 2'd2,
    OP_NOP     = 2'd3
  } op_e;
endpackage

// File: rtl/mcs_task_entry.sv
module mcs_task_entry #(
  parameter int TIME_W = 16,
  parameter int SEQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_cls,
  input  logic [TIME_W-1:0] cfg_period,
  input  logic [TIME_W-1:0] cfg_rel,
  input  logic              rm,
  input  logic              sw_rel,
  input  logic              done_clr,
  input  logic [SEQ_W-1:0]  seq_in,
  output logic              rel_req,
  output logic              valid_o,
  output logic              ready_o,
  output logic [1:0]        cls_o,
  output logic [TIME_W-1:0] period_o,
  output logic [TIME_W-1:0] dl_o,
  output logic [SEQ_W-1:0]  seq_o
);
  logic [TIME_W-1:0] rel_q;
  logic [TIME_W-1:0] cnt_q;
  logic              timer_fire;

  assign timer_fire = valid_o && (period_o != '0) && (cnt_q == TIME_W'(1));
  assign rel_req    = valid_o && !ready_o && (sw_rel || timer_fire) && !cfg_we && !rm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      ready_o  <= 1'b0;
      cls_o    <= '0;
      period_o <= '0;
      rel_q    <= '0;
      cnt_q    <= '0;
      dl_o     <= '0;
      seq_o    <= '0;
    end else if (cfg_we) begin
      valid_o  <= 1'b1;
      ready_o  <= 1'b0;
      cls_o    <= cfg_cls;
      period_o <= cfg_period;
      rel_q    <= cfg_rel;
      cnt_q    <= cfg_period;
      dl_o     <= '0;
      seq_o    <= '0;
    end else if (rm) begin
      valid_o <= 1'b0;
      ready_o <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (timer_fire)         cnt_q <= period_o;
      else if (cnt_q != '0)   cnt_q <= cnt_q - TIME_W'(1);
      if (rel_req) begin
        ready_o <= 1'b1;
        dl_o    <= now + rel_q;
        seq_o   <= seq_in;
      end else if (done_clr) begin
        ready_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mcs_select.sv
module mcs_select #(
  parameter int N      = 8,
  parameter int TIME_W = 16,
  parameter int SEQ_W  = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]             ready,
  input  logic [N-1:0][1:0]        cls,
  input  logic [N-1:0][TIME_W-1:0] period,
  input  logic [N-1:0][TIME_W-1:0] dl,
  input  logic [N-1:0][SEQ_W-1:0]  seq,
  output logic                     sel_valid,
  output logic [IDX_W-1:0]         sel_id
);
  import mcs_pkg::*;

  always_comb begin
    logic              win;
    logic [TIME_W-1:0] dl_diff;
    logic [SEQ_W-1:0]  seq_diff;
    sel_valid = 1'b0;
    sel_id    = '0;
    for (int i = 0; i < N; i++) begin
      win      = 1'b0;
      dl_diff  = dl[i] - dl[sel_id];
      seq_diff = seq[i] - seq[sel_id];
      if (!sel_valid) begin
        win = 1'b1;
      end else if (cls[i] != cls[sel_id]) begin
        win = cls[i] > cls[sel_id];
      end else begin
        case (cls[i])
          CLS_HARD: win = dl_diff[TIME_W-1];
          CLS_SOFT: win = period[i] < period[sel_id];
          default:  win = seq_diff[SEQ_W-1];
        endcase
      end
      if (ready[i] && win) begin
        sel_valid = 1'b1;
        sel_id    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mcs_sched.sv
module mcs_sched #(
  parameter int N      = 8,
  parameter int TIME_W = 16,
  parameter int SEQ_W  = 8,
  localparam int IDX_W = $clog2(N),
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_id,
  input  logic [1:0]        cmd_cls,
  input  logic [TIME_W-1:0] cmd_period,
  input  logic [TIME_W-1:0] cmd_rel_dl,
  input  logic              task_done,
  output logic              disp_valid,
  output logic [IDX_W-1:0]  disp_id
);
  import mcs_pkg::*;

  logic                     cmd_fire;
  logic [TIME_W-1:0]        now_q;
  logic [SEQ_W-1:0]         seq_ctr;
  logic [CNT_W-1:0]         rel_cnt;
  logic [N-1:0]             rel_req;
  logic [N-1:0]             valid_vec;
  logic [N-1:0]             ready_vec;
  logic [N-1:0][1:0]        cls_vec;
  logic [N-1:0][TIME_W-1:0] period_vec;
  logic [N-1:0][TIME_W-1:0] dl_vec;
  logic [N-1:0][SEQ_W-1:0]  seq_vec;
  logic [N-1:0][SEQ_W-1:0]  seq_in;
  logic                     sel_valid;
  logic [IDX_W-1:0]         sel_id;

  assign cmd_fire = cmd_valid && cmd_ready;

  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      seq_in[i] = seq_ctr + SEQ_W'(acc);
      acc       = acc + CNT_W'(rel_req[i]);
    end
    rel_cnt = acc;
  end

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic hit;
    assign hit = cmd_fire && (cmd_id == IDX_W'(g));
    mcs_task_entry #(.TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .now       (now_q),
      .cfg_we    (hit && (cmd_op == OP_CONFIG) && (cmd_cls != CLS_BAD)),
      .cfg_cls   (cmd_cls),
      .cfg_period(cmd_period),
      .cfg_rel   (cmd_rel_dl),
      .rm        (hit && (cmd_op == OP_REMOVE)),
      .sw_rel    (hit && (cmd_op == OP_RELEASE)),
      .done_clr  (task_done && disp_valid && (disp_id == IDX_W'(g))),
      .seq_in    (seq_in[g]),
      .rel_req   (rel_req[g]),
      .valid_o   (valid_vec[g]),
      .ready_o   (ready_vec[g]),
      .cls_o     (cls_vec[g]),
      .period_o  (period_vec[g]),
      .dl_o      (dl_vec[g]),
      .seq_o     (seq_vec[g])
    );
  end

  mcs_select #(.N(N), .TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_select (
    .ready    (ready_vec),
    .cls      (cls_vec),
    .period   (period_vec),
    .dl       (dl_vec),
    .seq      (seq_vec),
    .sel_valid(sel_valid),
    .sel_id   (sel_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready  <= 1'b0;
      now_q      <= '0;
      seq_ctr    <= '0;
      disp_valid <= 1'b0;
      disp_id    <= '0;
    end else begin
      cmd_ready  <= 1'b1;
      now_q      <= now_q + TIME_W'(1);
      seq_ctr    <= seq_ctr + SEQ_W'(rel_cnt);
      disp_valid <= sel_valid;
      disp_id    <= sel_id;
    end
  end
endmodule

// File: rtl/mcs_sched_chk.sv
module mcs_sched_chk #(
  parameter int N      = 8,
  localparam int IDX_W = $clog2(N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_valid,
  input logic [IDX_W-1:0]  disp_id,
  input logic              task_done,
  input logic [N-1:0]      ready_vec,
  input logic [N-1:0]      valid_vec,
  input logic [N-1:0][1:0] cls_vec
);
  logic [N-1:0]      prev_ready;
  logic [N-1:0][1:0] prev_cls;
  logic [1:0]        max_cls;
  logic [1:0]        prev_max;

  always_comb begin
    max_cls = '0;
    for (int i = 0; i < N; i++)
      if (ready_vec[i] && cls_vec[i] > max_cls) max_cls = cls_vec[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ready <= '0;
      prev_cls   <= '0;
      prev_max   <= '0;
    end else begin
      prev_ready <= ready_vec;
      prev_cls   <= cls_vec;
      prev_max   <= max_cls;
    end
  end

  AST_DISP_WAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> prev_ready[disp_id]); // R11
  AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid |-> (prev_ready == '0)); // R11
  AST_TOP_CLASS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (prev_cls[disp_id] == prev_max)); // R1
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_vec & ~valid_vec) == '0); // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (task_done && disp_valid) |=> !ready_vec[$past(disp_id)]); // R6
endmodule

bind mcs_sched mcs_sched_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .disp_valid(disp_valid),
  .disp_id   (disp_id),
  .task_done (task_done),
  .ready_vec (ready_vec),
  .valid_vec (valid_vec),
  .cls_vec   (cls_vec)
);

// File: tb/mcs_sched_tb.sv
module mcs_sched_tb;
  localparam int N      = 8;
  localparam int TIME_W = 16;
  localparam int SEQ_W  = 4;
  localparam int IDX_W  = $clog2(N);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [1:0]        cmd_op = '0;
  logic [IDX_W-1:0]  cmd_id = '0;
  logic [1:0]        cmd_cls = '0;
  logic [TIME_W-1:0] cmd_period = '0;
  logic [TIME_W-1:0] cmd_rel_dl = '0;
  logic              task_done = 1'b0;
  logic              disp_valid;
  logic [IDX_W-1:0]  disp_id;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct {
    bit    v;
    int    id;
    string tag;
  } exp_t;
  exp_t  exp_q[$];
  event  ev_sample;

  always #4 clk = ~clk;

  mcs_sched #(.N(N), .TIME_W(TIME_W), .SEQ_W(SEQ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_cls(cmd_cls), .cmd_period(cmd_period),
    .cmd_rel_dl(cmd_rel_dl), .task_done(task_done), .disp_valid(disp_valid),
    .disp_id(disp_id)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected dispatch items and compares them with the outputs
  initial begin
    forever begin
      @(ev_sample);
      while (exp_q.size() > 0) begin
        exp_t e;
        int   act;
        int   expv;
        e    = exp_q.pop_front();
        act  = disp_valid ? int'(disp_id) : -1;
        expv = e.v ? e.id : -1;
        check(act == expv, e.tag, act, expv);
      end
    end
  end

  task automatic expect_disp(bit v, int id, string tag);
    exp_t e;
    e.v = v; e.id = id; e.tag = tag;
    exp_q.push_back(e);
    -> ev_sample;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send(int op, int id, int cls, int period, int rel);
    cmd_valid  = 1'b1;
    cmd_op     = 2'(op);
    cmd_id     = IDX_W'(id);
    cmd_cls    = 2'(cls);
    cmd_period = TIME_W'(period);
    cmd_rel_dl = TIME_W'(rel);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cfg(int id, int cls, int period, int rel);
    send(0, id, cls, period, rel);
  endtask
  task automatic rel(int id);
    send(1, id, 0, 0, 0);
  endtask
  task automatic rmv(int id);
    send(2, id, 0, 0, 0);
  endtask
  task automatic done();
    task_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    task_done = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    step();
    check(cmd_ready == 1'b1, "R10 cmd_ready after reset", cmd_ready, 1);
    expect_disp(0, 0, "R10 idle after reset");

    // R9: class 3 configure is ignored, so a later release finds an invalid entry
    cfg(3, 3, 0, 0);
    rel(3);
    step();
    expect_disp(0, 0, "R9 bad class ignored, R8 invalid release");

    // R2 first-come order; R11 latency
    cfg(7, 0, 0, 0);
    cfg(1, 0, 0, 0);
    rel(7);
    expect_disp(0, 0, "R11 no dispatch before next edge");
    rel(1);
    step();
    expect_disp(1, 7, "R2 earliest background release wins");
    rel(7);
    step();
    expect_disp(1, 7, "R8 re-release of ready task keeps its order");

    // R1 / R3 soft class
    cfg(6, 1, 3000, 0);
    cfg(2, 1, 5000, 0);
    rel(2);
    step();
    expect_disp(1, 2, "R1 soft beats background");
    rel(6);
    step();
    expect_disp(1, 6, "R3 shorter period wins");

    // R1 / R4 hard class
    cfg(0, 2, 0, 1000);
    cfg(5, 2, 0, 200);
    rel(0);
    step();
    expect_disp(1, 0, "R1 hard beats soft");
    rel(5);
    step();
    expect_disp(1, 5, "R4 nearer deadline wins over lower index");

    // R6 done chain
    done(); step(); expect_disp(1, 0, "R6 done moves to next hard");
    done(); step(); expect_disp(1, 6, "R6 then shortest soft");
    done(); step(); expect_disp(1, 2, "R6 then next soft");
    done(); step(); expect_disp(1, 7, "R6 then oldest background");
    done(); step(); expect_disp(1, 1, "R6 then next background");
    done(); step(); expect_disp(0, 0, "R6 all retired");

    // R5 soft tie
    cfg(2, 1, 3000, 0);
    rel(6);
    rel(2);
    step();
    expect_disp(1, 2, "R5 soft tie to lower index");
    done(); step(); expect_disp(1, 6, "R5 soft tie second");
    done(); step(); expect_disp(0, 0, "R5 soft tie drained");
    rmv(6);
    rmv(2);

    // R5 hard tie: equal absolute deadlines from consecutive releases
    cfg(3, 2, 0, 101);
    cfg(1, 2, 0, 100);
    rel(3);
    rel(1);
    step();
    expect_disp(1, 1, "R5 hard tie to lower index");
    done(); step(); expect_disp(1, 3, "R5 hard tie second");
    done(); step(); expect_disp(0, 0, "R5 hard tie drained");

    // R9 remove of the running task
    rel(5);
    step();
    expect_disp(1, 5, "R9 released before remove");
    rmv(5);
    step();
    expect_disp(0, 0, "R9 removed task leaves dispatch");

    // R7 periodic timer release
    cfg(4, 1, 40, 0);
    repeat (40) step();
    expect_disp(0, 0, "R7 not yet released at period edge");
    step();
    expect_disp(1, 4, "R7 first timer release");
    done();
    step();
    expect_disp(0, 0, "R7 retired after done");
    repeat (37) step();
    expect_disp(0, 0, "R7 waiting for second period");
    step();
    expect_disp(1, 4, "R7 second timer release");
    rmv(4);
    step();
    expect_disp(0, 0, "R9 periodic removed");

    // R4 deadline wrap: wait until the time base is past 35536
    repeat (40000) step();
    cfg(6, 2, 0, 30000);
    cfg(2, 2, 0, 100);
    rel(6);
    rel(2);
    step();
    expect_disp(1, 2, "R4 wrap-safe deadline order");
    done(); step(); expect_disp(1, 6, "R4 wrapped deadline next");
    done(); step(); expect_disp(0, 0, "R4 drained");

    // R2 sequence wrap: three releases per round, every alignment across wrap
    cfg(5, 0, 0, 0);
    cfg(0, 0, 0, 0);
    cfg(3, 0, 0, 0);
    for (int k = 0; k < 16; k++) begin
      rel(5);
      rel(0);
      rel(3);
      step();
      expect_disp(1, 5, "R2 wrap round first");
      done(); step(); expect_disp(1, 0, "R2 wrap round second");
      done(); step(); expect_disp(1, 3, "R2 wrap round third");
      done(); step(); expect_disp(0, 0, "R2 wrap round drained");
    end

    step();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule